// File: doc/BRIEF.md
# Infrared Bi-Phase Remote-Control Frame Transmitter

This block sends one 14-cell remote-control frame on request. A sender offers a 5-bit device address, a 7-bit command and a toggle flag with a valid/ready handshake. The block packs these fields into a fixed frame layout and sends the cells most significant first. Each cell is bi-phase coded as two half-cells of opposite level, so two adjacent halves of the same level merge into one longer mark or space. During a mark half the LED output carries a pulse-width carrier. During a space half the output is held low.

The half-cell time and the carrier are both derived from the system clock by rounded integer division. `busy` stays high for the whole frame. `done` pulses once when the frame has finished. While a frame is in flight `in_ready` is low. This block has no input queue: a request that is offered while `in_ready` is low is not stored. The sender must hold `in_valid` until it sees `in_ready` high, or the request is lost. When `in_ready` is high, a request is taken in the same cycle and the data need not be held afterwards.

Top module: `ir5_frame_tx`

## Requirements
- R1: The frame is 14 bits. Bit 13 is a constant 1, bit 12 is command bit 6, bit 11 is the toggle flag, bits 10..6 are the address, and bits 5..0 are command bits 5..0. Cells are sent starting at bit 13 and ending at bit 0.
- R2: Each cell is two halves of HALF_CYC = round(CLK_HZ*HALF_US/1e6) clock cycles each. With ONE_SPACE_FIRST=1 (the default), a 1 is sent as space then mark and a 0 as mark then space.
- R3: With ONE_SPACE_FIRST=0, every cell is sent with the opposite half order: a 1 is mark then space and a 0 is space then mark.
- R4: Let n be the number of cycles counted from the cycle after acceptance. During a mark half, `ir_out` is 1 exactly when (n mod CAR_CYC) < CAR_ON. Here CAR_CYC = round(CLK_HZ/CARRIER_HZ) and CAR_ON = round(CAR_CYC*DUTY_PCT/100). During a space half, `ir_out` is 0.
- R5: `in_ready` equals not `busy`. A request is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `busy` is high from the next cycle for exactly 28*HALF_CYC cycles.
- R6: An `in_valid` offered while `busy` is high is ignored: the frame in flight is unchanged, and no second frame follows it.
- R7: `done` is high for exactly one cycle, the first cycle after `busy` falls. At all other times it is low.
- R8: While reset is asserted and whenever `busy` is low, `ir_out` is 0. A reset during a frame aborts it and leaves `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block idle, request will be taken |
| in_addr | input | 5 | Device address |
| in_cmd | input | 7 | Command code |
| in_toggle | input | 1 | Toggle flag |
| ir_out | output | 1 | LED drive, carrier-gated |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the frame ends |

## Verification
The hardest case to reach from the ports is a request that arrives while a frame is being sent. That request must leave no trace. To check this, the stimulus raises `in_valid` with different field values in the middle of a frame. It then compares every cycle of the frame against a waveform computed from the requirements, and confirms that `busy` stays low after `done`. A reset applied in the middle of a frame covers the abort path. Frames made of all ones, of all zeros, and of mixed bits exercise both the merged halves and the single halves at cell boundaries. A second instance with the opposite polarity is driven by the same stimulus.

// File: rtl/ir5_pkg.sv
package ir5_pkg;
  localparam int FRAME_BITS = 14;
  localparam int HALVES     = 2 * FRAME_BITS;

  // rounded integer division for clock-derived periods
  function automatic int div_round(longint num, longint den);
    return int'((num + den / 2) / den);
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(logic [4:0] addr,
                                                       logic [6:0] cmd,
                                                       logic       tog);
    return {1'b1, cmd[6], tog, addr, cmd[5:0]};
  endfunction
endpackage

// File: rtl/ir5_period_cnt.sv
module ir5_period_cnt #(
  parameter int PERIOD = 2,
  parameter int W      = $clog2(PERIOD + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         run,
  output logic [W-1:0] cnt,
  output logic         last
);
  assign last = run && (cnt == W'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run)   cnt <= last ? '0 : cnt + 1'b1;
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < W'(PERIOD));
endmodule

// File: rtl/ir5_seq.sv
module ir5_seq
  import ir5_pkg::*;
#(
  parameter int HALF_CYC        = 889,
  parameter bit ONE_SPACE_FIRST = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [4:0] in_addr,
  input  logic [6:0] in_cmd,
  input  logic       in_toggle,
  output logic       accept,
  output logic       busy,
  output logic       done,
  output logic       mark
);
  localparam int TW = $clog2(HALF_CYC + 1);
  localparam int IW = $clog2(HALVES);

  logic [FRAME_BITS-1:0] sh_q;
  logic [IW-1:0]         half_idx;
  logic [TW-1:0]         tcnt;
  logic                  half_end, frame_end, cur_bit, first_mark;

  assign accept    = in_valid && !busy;
  assign frame_end = half_end && (half_idx == IW'(HALVES - 1));
  assign cur_bit   = sh_q[FRAME_BITS-1];

  ir5_period_cnt #(.PERIOD(HALF_CYC), .W(TW)) half_tmr_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .run(busy),
    .cnt(tcnt), .last(half_end)
  );

  generate
    if (ONE_SPACE_FIRST) begin : g_space_first
      assign first_mark = ~cur_bit;
    end else begin : g_mark_first
      assign first_mark = cur_bit;
    end
  endgenerate

  assign mark = half_idx[0] ? ~first_mark : first_mark;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      half_idx <= '0;
      sh_q     <= '0;
    end else begin
      done <= frame_end;
      if (accept) begin
        busy     <= 1'b1;
        half_idx <= '0;
        sh_q     <= build_frame(in_addr, in_cmd, in_toggle);
      end else if (half_end) begin
        if (frame_end) begin
          busy     <= 1'b0;
          half_idx <= '0;
        end else begin
          half_idx <= half_idx + 1'b1;
          if (half_idx[0]) sh_q <= sh_q << 1;
        end
      end
    end
  end

  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid && !frame_end) |=> (busy && (tcnt != '0 || half_idx != '0)));
  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R8
  idle_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (half_idx == '0 && tcnt == '0));
endmodule

// File: rtl/ir5_frame_tx.sv
module ir5_frame_tx
  import ir5_pkg::*;
#(
  parameter int CLK_HZ          = 1_000_000,
  parameter int HALF_US         = 889,
  parameter int CARRIER_HZ      = 36_000,
  parameter int DUTY_PCT        = 30,
  parameter bit ONE_SPACE_FIRST = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [4:0] in_addr,
  input  logic [6:0] in_cmd,
  input  logic       in_toggle,
  output logic       ir_out,
  output logic       busy,
  output logic       done
);
  localparam int HALF_CYC = div_round(longint'(CLK_HZ) * HALF_US, 1_000_000);
  localparam int CAR_CYC  = div_round(longint'(CLK_HZ), longint'(CARRIER_HZ));
  localparam int CAR_ON   = div_round(longint'(CAR_CYC) * DUTY_PCT, 100);
  localparam int CW       = $clog2(CAR_CYC + 1);

  logic          accept, mark, car_on;
  logic [CW-1:0] car_cnt;
  logic          car_last;

  ir5_seq #(.HALF_CYC(HALF_CYC), .ONE_SPACE_FIRST(ONE_SPACE_FIRST)) seq_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_cmd(in_cmd), .in_toggle(in_toggle), .accept(accept),
    .busy(busy), .done(done), .mark(mark)
  );

  ir5_period_cnt #(.PERIOD(CAR_CYC), .W(CW)) car_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .run(busy),
    .cnt(car_cnt), .last(car_last)
  );

  assign car_on   = car_cnt < CW'(CAR_ON);
  assign ir_out   = busy && mark && car_on;
  assign in_ready = !busy;

  // R4
  car_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (car_last && !accept) |=> (car_cnt == '0));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (in_ready && !ir_out));
endmodule

// File: tb/ir5_frame_tx_tb_top.sv
module ir5_frame_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 320;  // round(360000*889/1e6)
  localparam int CARP = 10;   // round(360000/36000)
  localparam int CON  = 3;    // round(10*30/100)
  localparam int FRC  = 28 * HALF;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_toggle = 1'b0;
  logic [4:0] in_addr = '0;
  logic [6:0] in_cmd = '0;
  logic in_ready, ir_out, busy, done;
  logic in_ready_b, ir_out_b, busy_b, done_b;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ir5_frame_tx #(.CLK_HZ(360_000)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_cmd(in_cmd), .in_toggle(in_toggle),
    .ir_out(ir_out), .busy(busy), .done(done));

  ir5_frame_tx #(.CLK_HZ(360_000), .ONE_SPACE_FIRST(1'b0)) dut_inv_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_b),
    .in_addr(in_addr), .in_cmd(in_cmd), .in_toggle(in_toggle),
    .ir_out(ir_out_b), .busy(busy_b), .done(done_b));

  // {addr, cmd, toggle, expected frame}
  localparam logic [26:0] VEC [4] = '{
    {5'h00, 7'h00, 1'b0, 14'h2000},
    {5'h1F, 7'h7F, 1'b1, 14'h3FFF},
    {5'h0A, 7'h35, 1'b0, 14'h22B5},
    {5'h15, 7'h40, 1'b1, 14'h3D40}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_mark(input logic [13:0] f, input int half, input bit pol);
    bit b, first;
    b = f[13 - half / 2];
    first = pol ? ~b : b;
    return (half % 2 == 1) ? ~first : first;
  endfunction

  task automatic run_frame(input logic [26:0] v, input bit poke);
    int err_a = 0, err_b = 0, err_busy = 0, fa_act = 0, fa_exp = 0, fb_act = 0, fb_exp = 0;
    logic [13:0] f;
    f = v[13:0];
    @(negedge clk);
    in_addr = v[26:22]; in_cmd = v[21:15]; in_toggle = v[14]; in_valid = 1'b1;
    chk(in_ready === 1'b1 && busy === 1'b0, "R5 ready before request", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    for (int n = 0; n < FRC; n++) begin
      bit ea, eb;
      ea = exp_mark(f, n / HALF, 1'b1) && ((n % CARP) < CON);
      eb = exp_mark(f, n / HALF, 1'b0) && ((n % CARP) < CON);
      if (ir_out !== ea) begin if (err_a == 0) begin fa_act = ir_out; fa_exp = ea; end err_a++; end
      if (ir_out_b !== eb) begin if (err_b == 0) begin fb_act = ir_out_b; fb_exp = eb; end err_b++; end
      if (busy !== 1'b1 || in_ready !== 1'b0 || done !== 1'b0) err_busy++;
      if (poke && n == 100) begin
        in_valid = 1'b1; in_addr = ~v[26:22]; in_cmd = ~v[21:15]; in_toggle = ~v[14];
      end
      if (poke && n == 101) in_valid = 1'b0;
      @(negedge clk);
    end
    chk(err_a == 0, poke ? "R6 waveform with mid-frame request" : "R1 R2 R4 waveform", fa_act, fa_exp);
    chk(err_b == 0, "R3 inverted polarity waveform", fb_act, fb_exp);
    chk(err_busy == 0, "R5 busy held for whole frame", err_busy, 0);
    chk(busy === 1'b0 && done === 1'b1 && done_b === 1'b1, "R7 done after last half", done, 1);
    chk(ir_out === 1'b0 && ir_out_b === 1'b0, "R8 idle after frame", ir_out, 0);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, poke ? "R6 no second frame" : "R7 done single cycle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ir_out === 1'b0 && busy === 1'b0 && done === 1'b0, "R8 reset state", ir_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && ir_out === 1'b0, "R5 idle ready", in_ready, 1);
    for (int i = 0; i < 4; i++) run_frame(VEC[i], 1'b0);
    run_frame(VEC[2], 1'b1);
    // mid-frame reset aborts the frame
    @(negedge clk);
    in_addr = 5'h03; in_cmd = 7'h11; in_toggle = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (1000) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ir_out === 1'b0 && busy === 1'b0 && ir_out_b === 1'b0, "R8 reset mid-frame idle", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && done === 1'b0, "R8 ready after abort", in_ready, 1);
    run_frame(VEC[3], 1'b0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150_000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule